// File: doc/BRIEF.md
# SPI Device Configuration and Response Shaper

This block sits on the device side of a generic SPI slave, between the serial shifter and the rest of the device. It holds two small registers. The configuration register at address 0x0000 sets the word width, the byte order, the clock-edge relation of receive and transmit, the polarity of the interrupt line and a wake request bit. The delay register at address 0x0001 sets how many filler bytes come before read data. Two ports can write these registers: the host port, which also reads them back, and an internal CPU port.

The settings act on the data path while it runs. A response begins with a start pulse. The transmit side first sends the programmed number of zero filler bytes. It then takes whole words and emits them one byte at a time, in the configured order. Each byte is held until the shifter accepts it. The receive side takes whole words from the shifter and returns them realigned to the configured order and width. The interrupt request from inside the device leaves the block at the configured polarity. A host write that sets the wake bit produces a one-cycle wake event.

Top module: `spi_cfg_shaper`

## Requirements
- R1: After reset, the configuration register reads 0x30 and the delay register reads 0x04. In the configuration register, bit 0 is word width, bit 1 is byte order, bit 4 is edge mode, bit 5 is polarity and bit 7 is wake. At reset, word32_o, big_endian_o and wake_evt_o are 0 and same_edge_o is 1.
- R2: A host write to address 0x0000 loads bit 0 as the word width (1 means 32-bit), bit 1 as the byte order (1 means big endian), bit 4 as the edge mode (1 means same edge) and bit 5 as the polarity (1 means active high). The new values appear on the outputs in the cycle after the write. Bits 2, 3 and 6 read as 0.
- R3: A host read returns the addressed register on host_rdata in the cycle after host_rd_en, and the value holds until the next read. Address 0x0001 returns the 8-bit delay. Any other address reads 0, and writes to it change nothing.
- R4: The CPU port writes bits 0, 1, 4 and 5 of address 0x0000 and all of address 0x0001. It never changes bit 7.
- R5: When the host and the CPU write the same register in one cycle, the host value is kept. When they write different registers, both writes take effect.
- R6: A host write to address 0x0000 with bit 7 set raises wake_evt_o for exactly the next cycle. Bit 7 stores the written value and reads back.
- R7: irq_o equals irq_req_i when the polarity bit is 1, and equals its inverse when the polarity bit is 0.
- R8: After rsp_start_i with delay D > 0, the block offers D bytes of value 0x00, each held until tx_byte_ready_i, before it asks for any data word.
- R9: With delay 0, the cycle after rsp_start_i asks directly for a data word, and no filler byte is offered.
- R10: An accepted word is sent as 4 bytes in 32-bit mode or 2 bytes in 16-bit mode. Little endian sends the lowest byte first. Big endian sends the highest used byte first. A new word is requested only once the last byte has been accepted.
- R11: A received word appears on rx_word_o one cycle after rx_word_valid_i, with the used bytes reversed in big-endian mode. In 16-bit mode bits 31:16 are 0.
- R12: rsp_start_i during a response restarts it from the filler phase and discards any bytes not yet sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_rd_en | input | 1 | Host register read strobe |
| host_addr | input | 16 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| cpu_wr_en | input | 1 | CPU register write strobe |
| cpu_addr | input | 16 | CPU register address |
| cpu_wdata | input | 8 | CPU write data |
| irq_req_i | input | 1 | Internal active-high interrupt request |
| irq_o | output | 1 | Interrupt line at configured polarity |
| wake_evt_o | output | 1 | One-cycle wake event |
| word32_o | output | 1 | 1 when 32-bit words are selected |
| big_endian_o | output | 1 | 1 when big-endian order is selected |
| same_edge_o | output | 1 | 1 when receive and transmit share a clock edge |
| rsp_start_i | input | 1 | Start of a read response |
| tx_word_valid_i | input | 1 | Transmit word offered |
| tx_word_i | input | 32 | Transmit word |
| tx_word_ready_o | output | 1 | Transmit word taken this cycle if valid |
| tx_byte_valid_o | output | 1 | Byte offered to the shifter |
| tx_byte_o | output | 8 | Byte to shift out |
| tx_byte_ready_i | input | 1 | Shifter accepts the byte |
| rx_word_valid_i | input | 1 | Received word strobe |
| rx_word_i | input | 32 | Received word from the shifter |
| rx_word_valid_o | output | 1 | Realigned word strobe |
| rx_word_o | output | 32 | Realigned received word |

## Verification
Each result has a fixed due cycle. Configuration outputs, irq_o polarity and the stored delay take effect in the cycle after the write edge. host_rdata, wake_evt_o and the receive word each follow their strobe by exactly one register. The transmit handshake outputs come from state, so they are valid in the same cycle as the state that makes them. The bench steps a behavioural model at every rising edge using the same inputs the design sees. It drives inputs on falling edges and compares every output a quarter period later. This way every result is checked in its due cycle, whatever the back-pressure pattern on the byte side.

// File: rtl/spi_shaper_pkg.sv
package spi_shaper_pkg;

  localparam int REG_W  = 8;

  localparam int B_WIDE = 0;
  localparam int B_BE   = 1;
  localparam int B_EDGE = 4;
  localparam int B_POL  = 5;
  localparam int B_WAKE = 7;

  typedef struct packed {
    logic wake;
    logic pol;
    logic same_edge;
    logic big_end;
    logic wide;
  } cfg_t;

  localparam cfg_t CFG_RST = '{wake: 1'b0, pol: 1'b1, same_edge: 1'b1,
                               big_end: 1'b0, wide: 1'b0};

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_FILL = 2'd1,
    TX_DATA = 2'd2
  } tx_state_e;

endpackage

// File: rtl/spi_byte_order.sv
module spi_byte_order #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              big_end_i,
  input  logic              full_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int NB   = WORD_W / 8;
  localparam int HALF = NB / 2;

  for (genvar gi = 0; gi < NB; gi++) begin : g_byte
    if (gi < HALF) begin : g_low
      assign word_o[gi*8 +: 8] = !big_end_i ? word_i[gi*8 +: 8] :
                                 full_i     ? word_i[(NB-1-gi)*8 +: 8] :
                                              word_i[(HALF-1-gi)*8 +: 8];
    end else begin : g_high
      assign word_o[gi*8 +: 8] = !full_i    ? 8'h00 :
                                 !big_end_i ? word_i[gi*8 +: 8] :
                                              word_i[(NB-1-gi)*8 +: 8];
    end
  end

endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_shaper_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DLY_W   = 8,
  parameter int DLY_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr_en,
  input  logic              h_rd_en,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [REG_W-1:0]  h_wdata,
  output logic [REG_W-1:0]  h_rdata,
  input  logic              c_wr_en,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [REG_W-1:0]  c_wdata,
  output cfg_t              cfg_o,
  output logic [DLY_W-1:0]  delay_o,
  output logic              wake_evt_o
);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DLY = ADDR_W'(1);

  cfg_t             cfg_q, cfg_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic [REG_W-1:0] rd_q, rd_d, rd_val;
  logic             wake_q, wake_d;
  logic             h_cfg_hit, h_dly_hit, c_cfg_hit, c_dly_hit;
  logic             cfg_en, dly_en;

  always_comb begin
    h_cfg_hit = h_wr_en && (h_addr == A_CFG);
    h_dly_hit = h_wr_en && (h_addr == A_DLY);
    c_cfg_hit = c_wr_en && (c_addr == A_CFG);
    c_dly_hit = c_wr_en && (c_addr == A_DLY);
    cfg_en    = h_cfg_hit || c_cfg_hit;
    dly_en    = h_dly_hit || c_dly_hit;

    cfg_d = cfg_q;
    if (h_cfg_hit) begin
      cfg_d.wide      = h_wdata[B_WIDE];
      cfg_d.big_end   = h_wdata[B_BE];
      cfg_d.same_edge = h_wdata[B_EDGE];
      cfg_d.pol       = h_wdata[B_POL];
      cfg_d.wake      = h_wdata[B_WAKE];
    end else if (c_cfg_hit) begin
      cfg_d.wide      = c_wdata[B_WIDE];
      cfg_d.big_end   = c_wdata[B_BE];
      cfg_d.same_edge = c_wdata[B_EDGE];
      cfg_d.pol       = c_wdata[B_POL];
    end

    dly_d = dly_q;
    if (h_dly_hit)      dly_d = h_wdata[DLY_W-1:0];
    else if (c_dly_hit) dly_d = c_wdata[DLY_W-1:0];

    wake_d = h_cfg_hit && h_wdata[B_WAKE];

    rd_val = '0;
    if (h_addr == A_CFG) begin
      rd_val[B_WIDE] = cfg_q.wide;
      rd_val[B_BE]   = cfg_q.big_end;
      rd_val[B_EDGE] = cfg_q.same_edge;
      rd_val[B_POL]  = cfg_q.pol;
      rd_val[B_WAKE] = cfg_q.wake;
    end else if (h_addr == A_DLY) begin
      rd_val[DLY_W-1:0] = dly_q;
    end
    rd_d = h_rd_en ? rd_val : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RST;
      dly_q  <= DLY_W'(DLY_RST);
      rd_q   <= '0;
      wake_q <= 1'b0;
    end else begin
      if (cfg_en)  cfg_q <= cfg_d;
      if (dly_en)  dly_q <= dly_d;
      if (h_rd_en) rd_q  <= rd_d;
      wake_q <= wake_d;
    end
  end

  assign cfg_o      = cfg_q;
  assign delay_o    = dly_q;
  assign h_rdata    = rd_q;
  assign wake_evt_o = wake_q;

  assert_wake_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt_o |-> $past(h_wr_en && (h_addr == A_CFG) && h_wdata[B_WAKE]));

  assert_cpu_no_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_wr_en && (h_addr == A_CFG)) |=> $stable(cfg_o.wake));

  assert_stray_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr_en && (h_addr != A_CFG) && (h_addr != A_DLY) && !c_wr_en)
      |=> ($stable(cfg_o) && $stable(delay_o)));

endmodule

// File: rtl/spi_tx_shaper.sv
module spi_tx_shaper
  import spi_shaper_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_end_i,
  input  logic              wide_i,
  input  logic [DLY_W-1:0]  delay_i,
  input  logic              rsp_start_i,
  input  logic              tx_word_valid_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic              tx_word_ready_o,
  output logic              tx_byte_valid_o,
  output logic [7:0]        tx_byte_o,
  input  logic              tx_byte_ready_i
);
  localparam int NB     = WORD_W / 8;
  localparam int HALF   = NB / 2;
  localparam int LEFT_W = $clog2(NB + 1);

  tx_state_e         st_q, st_d;
  logic [DLY_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] buf_q, buf_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic [WORD_W-1:0] ordered;

  spi_byte_order #(.WORD_W(WORD_W)) i_order (
    .word_i    (tx_word_i),
    .big_end_i (big_end_i),
    .full_i    (wide_i),
    .word_o    (ordered)
  );

  always_comb begin
    tx_byte_valid_o = (st_q == TX_FILL) || ((st_q == TX_DATA) && (left_q != '0));
    tx_byte_o       = (st_q == TX_FILL) ? 8'h00 : buf_q[7:0];
    tx_word_ready_o = (st_q == TX_DATA) && (left_q == '0);

    st_d   = st_q;
    cnt_d  = cnt_q;
    buf_d  = buf_q;
    left_d = left_q;

    if (rsp_start_i) begin
      left_d = '0;
      if (delay_i == '0) begin
        st_d = TX_DATA;
      end else begin
        st_d  = TX_FILL;
        cnt_d = delay_i;
      end
    end else begin
      case (st_q)
        TX_FILL: begin
          if (tx_byte_ready_i) begin
            cnt_d = cnt_q - DLY_W'(1);
            if (cnt_q == DLY_W'(1)) st_d = TX_DATA;
          end
        end
        TX_DATA: begin
          if (left_q == '0) begin
            if (tx_word_valid_i) begin
              buf_d  = ordered;
              left_d = wide_i ? LEFT_W'(NB) : LEFT_W'(HALF);
            end
          end else if (tx_byte_ready_i) begin
            buf_d  = buf_q >> 8;
            left_d = left_q - LEFT_W'(1);
          end
        end
        default: st_d = TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      cnt_q  <= '0;
      buf_q  <= '0;
      left_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      buf_q  <= buf_d;
      left_q <= left_d;
    end
  end

  assert_fill_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_byte_valid_o && !tx_byte_ready_i && !rsp_start_i)
      |=> (tx_byte_valid_o && $stable(tx_byte_o)));

  assert_no_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_start_i && (delay_i == '0)) |=> (!tx_byte_valid_o && tx_word_ready_o));

endmodule

// File: rtl/spi_rx_align.sv
module spi_rx_align #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_end_i,
  input  logic              wide_i,
  input  logic              rx_valid_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic              rx_valid_o,
  output logic [WORD_W-1:0] rx_word_o
);
  localparam int HALF_W = WORD_W / 2;

  logic [WORD_W-1:0] aligned;
  logic [WORD_W-1:0] word_q;
  logic              valid_q;

  spi_byte_order #(.WORD_W(WORD_W)) i_order (
    .word_i    (rx_word_i),
    .big_end_i (big_end_i),
    .full_i    (wide_i),
    .word_o    (aligned)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rx_valid_i;
      if (rx_valid_i) word_q <= aligned;
    end
  end

  assign rx_valid_o = valid_q;
  assign rx_word_o  = word_q;

  assert_rx_upper_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && !wide_i) |=> (rx_valid_o && (rx_word_o[WORD_W-1:HALF_W] == '0)));

endmodule

// File: rtl/spi_cfg_shaper.sv
module spi_cfg_shaper
  import spi_shaper_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int WORD_W  = 32,
  parameter int DLY_W   = 8,
  parameter int DLY_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic              host_rd_en,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              cpu_wr_en,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              irq_req_i,
  output logic              irq_o,
  output logic              wake_evt_o,
  output logic              word32_o,
  output logic              big_endian_o,
  output logic              same_edge_o,
  input  logic              rsp_start_i,
  input  logic              tx_word_valid_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic              tx_word_ready_o,
  output logic              tx_byte_valid_o,
  output logic [7:0]        tx_byte_o,
  input  logic              tx_byte_ready_i,
  input  logic              rx_word_valid_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic              rx_word_valid_o,
  output logic [WORD_W-1:0] rx_word_o
);
  logic [1:0]       rst_sync_q;
  logic             core_rst_n;
  cfg_t             cfg;
  logic [DLY_W-1:0] delay;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  spi_cfg_regs #(
    .ADDR_W  (ADDR_W),
    .DLY_W   (DLY_W),
    .DLY_RST (DLY_RST)
  ) i_regs (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .h_wr_en    (host_wr_en),
    .h_rd_en    (host_rd_en),
    .h_addr     (host_addr),
    .h_wdata    (host_wdata),
    .h_rdata    (host_rdata),
    .c_wr_en    (cpu_wr_en),
    .c_addr     (cpu_addr),
    .c_wdata    (cpu_wdata),
    .cfg_o      (cfg),
    .delay_o    (delay),
    .wake_evt_o (wake_evt_o)
  );

  spi_tx_shaper #(
    .WORD_W (WORD_W),
    .DLY_W  (DLY_W)
  ) i_tx (
    .clk             (clk),
    .rst_n           (core_rst_n),
    .big_end_i       (cfg.big_end),
    .wide_i          (cfg.wide),
    .delay_i         (delay),
    .rsp_start_i     (rsp_start_i),
    .tx_word_valid_i (tx_word_valid_i),
    .tx_word_i       (tx_word_i),
    .tx_word_ready_o (tx_word_ready_o),
    .tx_byte_valid_o (tx_byte_valid_o),
    .tx_byte_o       (tx_byte_o),
    .tx_byte_ready_i (tx_byte_ready_i)
  );

  spi_rx_align #(.WORD_W(WORD_W)) i_rx (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .big_end_i  (cfg.big_end),
    .wide_i     (cfg.wide),
    .rx_valid_i (rx_word_valid_i),
    .rx_word_i  (rx_word_i),
    .rx_valid_o (rx_word_valid_o),
    .rx_word_o  (rx_word_o)
  );

  assign irq_o        = irq_req_i ^ ~cfg.pol;
  assign word32_o     = cfg.wide;
  assign big_endian_o = cfg.big_end;
  assign same_edge_o  = cfg.same_edge;

  assert_irq_follow_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
    $stable(irq_req_i) && !$past(host_wr_en || cpu_wr_en) |-> $stable(irq_o));

endmodule

// File: tb/test_spi_cfg_shaper.sv
module test_spi_cfg_shaper;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr_en, host_rd_en, cpu_wr_en;
  logic [15:0] host_addr, cpu_addr;
  logic [7:0]  host_wdata, cpu_wdata, host_rdata;
  logic        irq_req, irq_o, wake_evt_o, word32_o, big_endian_o, same_edge_o;
  logic        rsp_start, tx_word_valid, tx_word_ready_o, tx_byte_valid_o, tx_byte_ready;
  logic [31:0] tx_word, rx_word, rx_word_o;
  logic [7:0]  tx_byte_o;
  logic        rx_word_valid, rx_word_valid_o;

  always #(CLK_P/2) clk = ~clk;

  spi_cfg_shaper i_spi_cfg_shaper (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_rd_en(host_rd_en), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cpu_wr_en(cpu_wr_en), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .irq_req_i(irq_req), .irq_o(irq_o), .wake_evt_o(wake_evt_o),
    .word32_o(word32_o), .big_endian_o(big_endian_o), .same_edge_o(same_edge_o),
    .rsp_start_i(rsp_start), .tx_word_valid_i(tx_word_valid), .tx_word_i(tx_word),
    .tx_word_ready_o(tx_word_ready_o), .tx_byte_valid_o(tx_byte_valid_o),
    .tx_byte_o(tx_byte_o), .tx_byte_ready_i(tx_byte_ready),
    .rx_word_valid_i(rx_word_valid), .rx_word_i(rx_word),
    .rx_word_valid_o(rx_word_valid_o), .rx_word_o(rx_word_o)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  string phase = "R1";
  bit    rdy_pat = 1'b0;
  int    pat_cnt = 0;

  // behavioural reference state
  bit        m_w32, m_be, m_edge, m_pol, m_wake, m_wevt, m_rxv;
  int        m_dly, m_cnt, m_st;   // m_st: 0 idle, 1 filler, 2 data
  bit [7:0]  m_rdata;
  bit [31:0] m_rxw;
  bit [7:0]  m_q[$];

  task automatic m_reset();
    m_w32 = 0; m_be = 0; m_edge = 1; m_pol = 1; m_wake = 0; m_wevt = 0;
    m_dly = 4; m_cnt = 0; m_st = 0; m_rdata = 0; m_rxv = 0; m_rxw = 0;
    m_q.delete();
  endtask

  function automatic bit [31:0] realign(bit [31:0] w, bit be, bit w32);
    bit [31:0] r = 0;
    int n = w32 ? 4 : 2;
    for (int i = 0; i < n; i++) r[i*8 +: 8] = be ? w[(n-1-i)*8 +: 8] : w[i*8 +: 8];
    return r;
  endfunction

  always @(posedge clk) begin
    bit hc, hd, cc, cd;
    int n;
    cyc++;
    if (!rst_n) m_reset();
    else begin
      hc = host_wr_en && host_addr == 16'h0000;
      hd = host_wr_en && host_addr == 16'h0001;
      cc = cpu_wr_en && cpu_addr == 16'h0000;
      cd = cpu_wr_en && cpu_addr == 16'h0001;
      if (host_rd_en)
        m_rdata = host_addr == 16'h0000 ? {m_wake, 1'b0, m_pol, m_edge, 2'b00, m_be, m_w32} :
                  host_addr == 16'h0001 ? 8'(m_dly) : 8'h00;
      m_wevt = hc && host_wdata[7];
      m_rxv = rx_word_valid;
      if (rx_word_valid) m_rxw = realign(rx_word, m_be, m_w32);
      if (rsp_start) begin
        m_q.delete();
        if (m_dly == 0) m_st = 2;
        else begin m_st = 1; m_cnt = m_dly; end
      end else if (m_st == 1) begin
        if (tx_byte_ready) begin
          m_cnt--;
          if (m_cnt == 0) m_st = 2;
        end
      end else if (m_st == 2) begin
        if (m_q.size() == 0) begin
          if (tx_word_valid) begin
            n = m_w32 ? 4 : 2;
            if (m_be) for (int i = n-1; i >= 0; i--) m_q.push_back(tx_word[i*8 +: 8]);
            else      for (int i = 0; i < n; i++)     m_q.push_back(tx_word[i*8 +: 8]);
          end
        end else if (tx_byte_ready) void'(m_q.pop_front());
      end
      if (hc) begin
        m_w32 = host_wdata[0]; m_be = host_wdata[1]; m_edge = host_wdata[4];
        m_pol = host_wdata[5]; m_wake = host_wdata[7];
      end else if (cc) begin
        m_w32 = cpu_wdata[0]; m_be = cpu_wdata[1]; m_edge = cpu_wdata[4]; m_pol = cpu_wdata[5];
      end
      if (hd) m_dly = host_wdata;
      else if (cd) m_dly = cpu_wdata;
    end
  end

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit ev;
    #(CLK_P/4);
    ev = (m_st == 1) || (m_st == 2 && m_q.size() > 0);
    cmp("host_rdata", host_rdata, m_rdata);
    cmp("wake_evt", wake_evt_o, m_wevt);
    cmp("word32", word32_o, m_w32);
    cmp("big_endian", big_endian_o, m_be);
    cmp("same_edge", same_edge_o, m_edge);
    cmp("irq", irq_o, m_pol ? irq_req : !irq_req);
    cmp("tx_byte_valid", tx_byte_valid_o, ev);
    cmp("tx_word_ready", tx_word_ready_o, m_st == 2 && m_q.size() == 0);
    if (ev) cmp("tx_byte", tx_byte_o, m_st == 1 ? 8'h00 : m_q[0]);
    cmp("rx_valid", rx_word_valid_o, m_rxv);
    if (m_rxv) cmp("rx_word", rx_word_o, m_rxw);
  end

  always @(negedge clk) begin
    tx_byte_ready = rdy_pat ? (pat_cnt % 3 != 2) : 1'b1;
    pat_cnt++;
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hwrite(logic [15:0] a, logic [7:0] d);
    @(negedge clk); host_wr_en = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr_en = 0;
  endtask

  task automatic hread(logic [15:0] a);
    @(negedge clk); host_rd_en = 1; host_addr = a;
    @(negedge clk); host_rd_en = 0;
  endtask

  task automatic cwrite(logic [15:0] a, logic [7:0] d);
    @(negedge clk); cpu_wr_en = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_wr_en = 0;
  endtask

  task automatic both(logic [15:0] ha, logic [7:0] hd, logic [15:0] ca, logic [7:0] cd);
    @(negedge clk); host_wr_en = 1; host_addr = ha; host_wdata = hd;
    cpu_wr_en = 1; cpu_addr = ca; cpu_wdata = cd;
    @(negedge clk); host_wr_en = 0; cpu_wr_en = 0;
  endtask

  task automatic rsp();
    @(negedge clk); rsp_start = 1;
    @(negedge clk); rsp_start = 0;
  endtask

  task automatic send_word(logic [31:0] w);
    @(negedge clk); tx_word_valid = 1; tx_word = w;
    #(CLK_P/4);
    while (!tx_word_ready_o) begin @(negedge clk); #(CLK_P/4); end
    @(negedge clk); tx_word_valid = 0;
  endtask

  task automatic rx_send(logic [31:0] w);
    @(negedge clk); rx_word_valid = 1; rx_word = w;
    @(negedge clk); rx_word_valid = 0;
  endtask

  initial begin
    m_reset();
    host_wr_en = 0; host_rd_en = 0; host_addr = 0; host_wdata = 0;
    cpu_wr_en = 0; cpu_addr = 0; cpu_wdata = 0; irq_req = 0;
    rsp_start = 0; tx_word_valid = 0; tx_word = 0; tx_byte_ready = 1;
    rx_word_valid = 0; rx_word = 0;
    rst_n = 1;
    #1 rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(4);

    phase = "R1";  // reset readback: 0x30 and 0x04
    hread(16'h0000); hread(16'h0001); idle(2);

    phase = "R2";
    hwrite(16'h0000, 8'h13); hread(16'h0000); idle(2);
    hwrite(16'h0000, 8'h4C); hread(16'h0000); idle(2);

    phase = "R6";
    hwrite(16'h0000, 8'hB3); hread(16'h0000); idle(2);
    hwrite(16'h0000, 8'h31); hread(16'h0000); idle(2);

    phase = "R7";
    for (int i = 0; i < 4; i++) begin @(negedge clk); irq_req = i[0]; end
    hwrite(16'h0000, 8'h11);
    for (int i = 0; i < 4; i++) begin @(negedge clk); irq_req = !i[0]; end
    hwrite(16'h0000, 8'h31); irq_req = 0; idle(2);

    phase = "R3";
    hwrite(16'h0001, 8'h02); hread(16'h0001);
    hwrite(16'h0005, 8'hFF); hread(16'h0005);
    hwrite(16'h8000, 8'h00); hread(16'h0000); hread(16'h0001); idle(2);

    phase = "R4";
    hwrite(16'h0000, 8'hB1);
    cwrite(16'h0000, 8'h42); hread(16'h0000);
    cwrite(16'h0000, 8'h00); hread(16'h0000);
    cwrite(16'h0001, 8'h05); hread(16'h0001); idle(2);

    phase = "R5";
    both(16'h0000, 8'h11, 16'h0000, 8'h22); hread(16'h0000);
    both(16'h0001, 8'h01, 16'h0000, 8'h33); hread(16'h0000); hread(16'h0001);
    both(16'h0001, 8'h07, 16'h0001, 8'h09); hread(16'h0001); idle(2);

    phase = "R8";
    rdy_pat = 1;
    hwrite(16'h0000, 8'h31); hwrite(16'h0001, 8'h03);
    rsp(); send_word(32'h11223344); send_word(32'hA5B6C7D8); idle(12);

    phase = "R9";
    hwrite(16'h0001, 8'h00); hwrite(16'h0000, 8'h32);
    rsp(); send_word(32'hDEADBEEF); idle(6);

    phase = "R10";
    hwrite(16'h0000, 8'h33); send_word(32'h01020304);
    hwrite(16'h0000, 8'h30); send_word(32'hCAFEF00D);
    hwrite(16'h0000, 8'h31); send_word(32'h55667788); idle(10);

    phase = "R11";
    hwrite(16'h0000, 8'h33); rx_send(32'h0A0B0C0D);
    hwrite(16'h0000, 8'h32); rx_send(32'h0A0B0C0D);
    hwrite(16'h0000, 8'h30); rx_send(32'h12345678);
    hwrite(16'h0000, 8'h31); rx_send(32'h87654321); idle(2);

    phase = "R12";
    hwrite(16'h0001, 8'h02);
    rsp(); rsp(); idle(4);
    send_word(32'h99AABBCC); rsp(); idle(6);
    send_word(32'h13579BDF); idle(8);
    rdy_pat = 0; idle(4);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule